// File: doc/BRIEF.md
# Descriptor Entry Chain Walker

This block traverses the chain of variable-length records stored after the fixed 22-byte header of a descriptor image. The image sits in a byte-wide memory that the block reads through a simple read port with one cycle of latency. A start pulse carries the total image size in bytes. From then on the block fetches each record's length and type bytes. It checks that the record fits inside the image, and then jumps to the next record by adding that length to its position.

A record whose type bit marks it as a port record produces a single result strobe for the port index it names. If the record's disable bit is clear, the strobe carries the link number and any dual-link partner decoded from the record body. Other records are passed over. The walk ends with a one-cycle completion pulse. An overrun flag reports that the chain ran off the end of the image, and a separate flag reports that a port record had the wrong length. Both flags hold until the next start.

Top module: `entry_chain_walker`

## Requirements
- R1: On `start` while idle the block latches `imageSize` and begins at byte position 22; if that position is already at or beyond the size, it completes with no strobe and with both error flags clear.
- R2: A read is requested by `memRd` with `memAddr` in one cycle, and `memData` is taken in the next cycle; every address read lies below the latched size.
- R3: If the position at the start of a record equals size minus 1, the walk stops with `overrun` set.
- R4: If a record's length byte (record byte 0) is zero, or position plus length exceeds the size, the walk stops with `overrun` set; `overrun` and `done` rise in the same cycle, and `overrun` holds until the next start.
- R5: Record byte 1 holds the port index in bits 5:0, a disable flag in bit 6, and the record type in bit 7 (1 = port, 0 = generic).
- R6: Generic records produce no strobe and are stepped over.
- R7: A port record with bit 6 set produces exactly one strobe with `portDis`=1 and `portLink`, `partnerValid` and `partnerNum` all 0.
- R8: An enabled port record of length 8 produces one strobe with `portLink` = byte 2 bit 4, `partnerValid` = byte 2 bit 7, and `partnerNum` = byte 3 bits 5:0.
- R9: An enabled port record whose length is not 8 sets `malformed`, produces no strobe, and the walk carries on with the next record.
- R10: After each record the position advances by its length; when the position reaches or passes the size with no fault, `done` pulses for exactly one cycle and `overrun` stays clear.
- R11: A `start` pulse that arrives while `busy` is high is ignored and does not disturb the walk in progress.
- R12: After reset the block is idle, with `busy`, `done`, `portWe`, `memRd`, `overrun` and `malformed` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| imageSize | input | ADDR_W | Total image size in bytes |
| memRd | output | 1 | Read request |
| memAddr | output | ADDR_W | Read byte address |
| memData | input | 8 | Read data, valid the cycle after `memRd` |
| portWe | output | 1 | Port result strobe |
| portIdx | output | 6 | Port index of the strobed result |
| portDis | output | 1 | Port is marked disabled |
| portLink | output | 1 | Link number of the port |
| partnerValid | output | 1 | A dual-link partner exists |
| partnerNum | output | 6 | Partner port number |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Chain left the image bounds (held until next start) |
| malformed | output | 1 | A port record had a bad length (held until next start) |

## Verification
The bench goes after the bound conditions one by one. It covers a header-only image, a record that starts on the last byte, a zero-length record that would otherwise loop forever, and a record that ends one byte past the image. A design with an off-by-one in these comparisons would either read past the image or flag a legal chain that ends exactly at the size. It also covers a wrongly sized port record followed by a good one: a design that aborted there would lose the later strobe, and one that decoded the record anyway would emit a spurious result. A start pulse in mid-walk and a long sweep of generated chains, compared against an arithmetic model, catch stray restarts and wrong field positions.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

  localparam int PORT_IDX_W = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_LEN, S_TYP, S_DECIDE, S_B2, S_B3, S_EMIT, S_FIN
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       rd;
    logic [1:0] ofs;
    logic       capLen;
    logic       capTyp;
    logic       capB2;
    logic       capB3;
    logic       advance;
    logic       emit;
  } walkCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic atEnd;
    logic lastByte;
    logic badLen;
    logic isPort;
    logic isDisabled;
    logic lenIsPort;
  } walkFlags_t;

endpackage

// File: rtl/ecw_dpath.sv
module ecw_dpath
  import ecw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int HDR_BYTES  = 22,
  parameter int PORT_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkCmd_t              cmd,
  input  logic [ADDR_W-1:0]     startSize,
  input  logic [7:0]            memData,
  output walkFlags_t            flags,
  output logic                  memRd,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [PORT_IDX_W-1:0] portIdx,
  output logic                  portDis,
  output logic                  portLink,
  output logic                  partnerValid,
  output logic [PORT_IDX_W-1:0] partnerNum
);

  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0]     pos;
  logic [ADDR_W-1:0]     size;
  logic [7:0]            lenReg;
  logic [7:0]            typReg;
  logic                  linkBit;
  logic                  pairBit;
  logic [PORT_IDX_W-1:0] pairNum;

  logic [EXT_W-1:0] posExt;
  logic [EXT_W-1:0] sizeExt;
  logic [EXT_W-1:0] endExt;

  assign posExt  = {1'b0, pos};
  assign sizeExt = {1'b0, size};
  assign endExt  = posExt + EXT_W'(lenReg);

  always_comb begin
    flags.atEnd      = (pos >= size);
    flags.lastByte   = (posExt + EXT_W'(1) == sizeExt);
    flags.badLen     = (lenReg == 8'd0) || (endExt > sizeExt);
    flags.isPort     = typReg[7];
    flags.isDisabled = typReg[6];
    flags.lenIsPort  = (lenReg == 8'(PORT_BYTES));
  end

  assign memRd   = cmd.rd;
  assign memAddr = pos + ADDR_W'(cmd.ofs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos     <= '0;
      size    <= '0;
      lenReg  <= '0;
      typReg  <= '0;
      linkBit <= 1'b0;
      pairBit <= 1'b0;
      pairNum <= '0;
    end else begin
      if (cmd.load) begin
        pos  <= ADDR_W'(HDR_BYTES);
        size <= startSize;
      end else if (cmd.advance) begin
        pos <= pos + ADDR_W'(lenReg);
      end
      if (cmd.capLen) lenReg <= memData;
      if (cmd.capTyp) typReg <= memData;
      if (cmd.capB2) begin
        linkBit <= memData[4];
        pairBit <= memData[7];
      end
      if (cmd.capB3) pairNum <= memData[PORT_IDX_W-1:0];
    end
  end

  // result fields; a disabled port reports no link data
  assign portIdx      = typReg[PORT_IDX_W-1:0];
  assign portDis      = typReg[6];
  assign portLink     = !typReg[6] && linkBit;
  assign partnerValid = !typReg[6] && pairBit;
  assign partnerNum   = typReg[6] ? '0 : pairNum;

  a_r2_read_in_image: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rd |-> (memAddr < size));

  a_r4_emit_in_bounds: assert property (@(posedge clk) disable iff (!rstN)
    cmd.emit |-> ((endExt <= sizeExt) && (lenReg != 8'd0)));

  a_r8_emit_port_len: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.emit && !typReg[6]) |-> (lenReg == 8'(PORT_BYTES)));

  a_r10_advance_forward: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> (pos > $past(pos)));

endmodule

// File: rtl/ecw_ctrl.sv
module ecw_ctrl
  import ecw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  walkFlags_t flags,
  output walkCmd_t   cmd,
  output logic       busy,
  output logic       done,
  output logic       overrun,
  output logic       malformed
);

  walkState_t state, stateNext;
  logic setOver;
  logic setMal;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    setOver   = 1'b0;
    setMal    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          cmd.load  = 1'b1;
          stateNext = S_CHECK;
        end
      end
      S_CHECK: begin
        if (flags.atEnd) begin
          stateNext = S_FIN;
        end else if (flags.lastByte) begin
          setOver   = 1'b1;
          stateNext = S_FIN;
        end else begin
          cmd.rd    = 1'b1;
          cmd.ofs   = 2'd0;
          stateNext = S_LEN;
        end
      end
      S_LEN: begin
        cmd.capLen = 1'b1;
        cmd.rd     = 1'b1;
        cmd.ofs    = 2'd1;
        stateNext  = S_TYP;
      end
      S_TYP: begin
        cmd.capTyp = 1'b1;
        stateNext  = S_DECIDE;
      end
      S_DECIDE: begin
        if (flags.badLen) begin
          setOver   = 1'b1;
          stateNext = S_FIN;
        end else if (!flags.isPort) begin
          cmd.advance = 1'b1;
          stateNext   = S_CHECK;
        end else if (flags.isDisabled) begin
          cmd.emit    = 1'b1;
          cmd.advance = 1'b1;
          stateNext   = S_CHECK;
        end else if (!flags.lenIsPort) begin
          setMal      = 1'b1;
          cmd.advance = 1'b1;
          stateNext   = S_CHECK;
        end else begin
          cmd.rd    = 1'b1;
          cmd.ofs   = 2'd2;
          stateNext = S_B2;
        end
      end
      S_B2: begin
        cmd.capB2 = 1'b1;
        cmd.rd    = 1'b1;
        cmd.ofs   = 2'd3;
        stateNext = S_B3;
      end
      S_B3: begin
        cmd.capB3 = 1'b1;
        stateNext = S_EMIT;
      end
      S_EMIT: begin
        cmd.emit    = 1'b1;
        cmd.advance = 1'b1;
        stateNext   = S_CHECK;
      end
      S_FIN: begin
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      overrun   <= 1'b0;
      malformed <= 1'b0;
    end else begin
      state <= stateNext;
      if (cmd.load) begin
        overrun   <= 1'b0;
        malformed <= 1'b0;
      end else begin
        if (setOver) overrun   <= 1'b1;
        if (setMal)  malformed <= 1'b1;
      end
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  a_r4_overrun_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> done);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_no_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmd.load);

  a_r9_malformed_holds: assert property (@(posedge clk) disable iff (!rstN)
    (malformed && busy) |=> malformed);

endmodule

// File: rtl/entry_chain_walker.sv
module entry_chain_walker
  import ecw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int HDR_BYTES  = 22,
  parameter int PORT_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [ADDR_W-1:0]     imageSize,
  output logic                  memRd,
  output logic [ADDR_W-1:0]     memAddr,
  input  logic [7:0]            memData,
  output logic                  portWe,
  output logic [PORT_IDX_W-1:0] portIdx,
  output logic                  portDis,
  output logic                  portLink,
  output logic                  partnerValid,
  output logic [PORT_IDX_W-1:0] partnerNum,
  output logic                  busy,
  output logic                  done,
  output logic                  overrun,
  output logic                  malformed
);

  walkCmd_t   cmd;
  walkFlags_t flags;

  ecw_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .flags     (flags),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .overrun   (overrun),
    .malformed (malformed)
  );

  ecw_dpath #(
    .ADDR_W     (ADDR_W),
    .HDR_BYTES  (HDR_BYTES),
    .PORT_BYTES (PORT_BYTES)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .startSize    (imageSize),
    .memData      (memData),
    .flags        (flags),
    .memRd        (memRd),
    .memAddr      (memAddr),
    .portIdx      (portIdx),
    .portDis      (portDis),
    .portLink     (portLink),
    .partnerValid (partnerValid),
    .partnerNum   (partnerNum)
  );

  assign portWe = cmd.emit;

endmodule

// File: tb/entry_chain_walker_tb_top.sv
module entry_chain_walker_tb_top;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] imageSize = '0;
  logic          memRd;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData = '0;
  logic          portWe, portDis, portLink, partnerValid, busy, done, overrun, malformed;
  logic [5:0]    portIdx, partnerNum;

  always #10 clk = ~clk;

  entry_chain_walker dut_i (
    .clk(clk), .rstN(rstN), .start(start), .imageSize(imageSize),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .portWe(portWe), .portIdx(portIdx), .portDis(portDis), .portLink(portLink),
    .partnerValid(partnerValid), .partnerNum(partnerNum),
    .busy(busy), .done(done), .overrun(overrun), .malformed(malformed)
  );

  logic [7:0] mem [0:2047];
  always @(posedge clk) if (memRd) memData <= mem[memAddr];

  // strobe record: {dis, link, pairValid, idx[5:0], partner[5:0]}
  logic [14:0] got [0:255];
  int gotCnt = 0;
  always @(negedge clk) begin
    if (portWe) begin
      got[gotCnt % 256] = {portDis, portLink, partnerValid, portIdx, partnerNum};
      gotCnt++;
    end
  end

  int nChk = 0;
  int nBad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of the walk, written from the requirements
  logic [14:0] expArr [0:255];
  int expN;
  bit expOver, expMal;

  function automatic void modelWalk(input int size);
    int p = 22;
    expN = 0; expOver = 0; expMal = 0;
    while (p < size) begin
      int len;
      logic [7:0] t;
      if (p + 1 == size) begin expOver = 1; break; end
      len = mem[p];
      t = mem[p+1];
      if (len == 0 || p + len > size) begin expOver = 1; break; end
      if (t[7]) begin
        if (t[6]) begin
          expArr[expN] = {1'b1, 1'b0, 1'b0, t[5:0], 6'd0}; expN++;
        end else if (len != 8) begin
          expMal = 1;
        end else begin
          expArr[expN] = {1'b0, mem[p+2][4], mem[p+2][7], t[5:0], mem[p+3][5:0]}; expN++;
        end
      end
      p += len;
    end
  endfunction

  logic [31:0] seed = 32'h1234_5678;
  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8);
  endfunction

  task automatic putEntry(inout int p, input int len, input logic [7:0] typ,
                          input logic [7:0] b2, input logic [7:0] b3);
    mem[p] = 8'(len);
    mem[p+1] = typ;
    mem[p+2] = b2;
    mem[p+3] = b3;
    for (int k = 4; k < len; k++) mem[p+k] = 8'hA5;
    p += len;
  endtask

  int lastBase;

  task automatic runWalk(input int size, input string tag, input bit midStart);
    int base, cyc, n;
    base = gotCnt;
    lastBase = base;
    modelWalk(size);
    @(negedge clk);
    imageSize = AW'(size); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      @(negedge clk);
      imageSize = AW'(size ^ 5); start = 1'b1;
      @(negedge clk);
      start = 1'b0; imageSize = AW'(size);
    end
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R10", {tag, " done seen"}, int'(done), 1);
    n = gotCnt - base;
    chk(n == expN, "R6", {tag, " strobe count"}, n, expN);
    for (int i = 0; i < n && i < expN; i++)
      chk(got[(base+i)%256] == expArr[i], "R8", {tag, " strobe fields"},
          int'(got[(base+i)%256]), int'(expArr[i]));
    chk(overrun == expOver, "R4", {tag, " overrun flag"}, int'(overrun), int'(expOver));
    chk(malformed == expMal, "R9", {tag, " malformed flag"}, int'(malformed), int'(expMal));
    @(negedge clk);
    chk(!done && !busy, "R10", {tag, " single done pulse"}, int'(done), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int p;
    for (int i = 0; i < 2048; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !portWe && !memRd && !overrun && !malformed,
        "R12", "reset outputs", int'({busy, done, portWe, memRd, overrun, malformed}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R12", "idle after reset", int'(busy), 0);

    // R1 header-only and smaller sizes
    runWalk(22, "R1 size22", 0);
    chk(gotCnt == lastBase && !overrun, "R1", "no strobe at size 22", gotCnt - lastBase, 0);
    runWalk(5, "R1 size5", 0);
    chk(!overrun && !malformed, "R1", "no error below header", int'(overrun), 0);

    // R3 record starting on last byte
    runWalk(23, "R3 size23", 0);
    chk(overrun == 1'b1, "R3", "overrun at size-1", int'(overrun), 1);
    p = 22; putEntry(p, 5, 8'h01, 8'h00, 8'h00);
    runWalk(28, "R3 chain end-1", 0);
    chk(overrun == 1'b1, "R3", "overrun at record on last byte", int'(overrun), 1);

    // R5 R6 R7 R8 R10 mixed chain, exact fit
    p = 22;
    putEntry(p, 5, 8'h03, 8'hFF, 8'hFF);              // generic
    putEntry(p, 8, 8'h85, 8'h90, 8'hC3);              // port 5, link1, partner 3
    putEntry(p, 8, 8'hCA, 8'hFF, 8'hFF);              // port 10 disabled
    putEntry(p, 8, 8'h81, 8'h00, 8'h3F);              // port 1, link0, no partner
    runWalk(p, "R10 mixed", 0);
    chk(got[lastBase%256] == {1'b0, 1'b1, 1'b1, 6'd5, 6'd3}, "R8", "port 5 fields",
        int'(got[lastBase%256]), int'({1'b0, 1'b1, 1'b1, 6'd5, 6'd3}));
    chk(got[(lastBase+1)%256] == {1'b1, 1'b0, 1'b0, 6'd10, 6'd0}, "R7", "disabled port 10",
        int'(got[(lastBase+1)%256]), int'({1'b1, 1'b0, 1'b0, 6'd10, 6'd0}));
    chk(got[(lastBase+2)%256][14:12] == 3'b000, "R5", "port 1 link/partner bits",
        int'(got[(lastBase+2)%256][14:12]), 0);
    chk(gotCnt - lastBase == 3 && !overrun, "R6", "generic skipped", gotCnt - lastBase, 3);

    // R11 start while busy ignored
    runWalk(p, "R11 mid start", 1);
    chk(gotCnt - lastBase == 3, "R11", "mid-walk start ignored", gotCnt - lastBase, 3);

    // R4 zero length
    p = 22; putEntry(p, 8, 8'h82, 8'h10, 8'h01); mem[p] = 8'd0; mem[p+1] = 8'h00;
    runWalk(p + 8, "R4 zero len", 0);
    chk(overrun == 1'b1 && gotCnt - lastBase == 1, "R4", "zero length overrun",
        int'(overrun), 1);

    // R4 overshoot by one byte
    p = 22; putEntry(p, 5, 8'h00, 8'h00, 8'h00); putEntry(p, 8, 8'h84, 8'h10, 8'h02);
    runWalk(p - 1, "R4 overshoot", 0);
    chk(overrun == 1'b1 && gotCnt == lastBase, "R4", "end past size", int'(overrun), 1);

    // R9 malformed port then good port
    p = 22; putEntry(p, 7, 8'h86, 8'h10, 8'h02); putEntry(p, 8, 8'h87, 8'h80, 8'h09);
    runWalk(p, "R9 malformed", 0);
    chk(malformed == 1'b1 && !overrun, "R9", "malformed flagged", int'(malformed), 1);
    chk(gotCnt - lastBase == 1 && got[lastBase%256][11:6] == 6'd7, "R9",
        "walk continues after bad record", gotCnt - lastBase, 1);

    // generated sweep
    for (int it = 0; it < 300; it++) begin
      int nEnt, sz, sel;
      for (int i = 22; i < 512; i++) mem[i] = 8'(rnd());
      p = 22;
      nEnt = int'(rnd() % 16);
      for (int e = 0; e < nEnt; e++) begin
        int len;
        sel = int'(rnd() % 10);
        case (sel)
          0: len = 1;
          1: len = 3;
          2: len = 5;
          3: len = 7;
          9: len = (rnd() % 4 == 0) ? 0 : 12;
          default: len = 8;
        endcase
        putEntry(p, len, 8'(rnd()), 8'(rnd()), 8'(rnd()));
        if (len == 0) p += 2;
      end
      sel = int'(rnd() % 6);
      sz = (sel == 0) ? p - 1 : (sel == 1) ? p + 3 : p;
      runWalk(sz, "sweep", 0);
    end

    summary();
    $finish;
  end

endmodule